// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller

This block connects a simple synchronous request port to an asynchronous-strobe dynamic RAM that holds 262144 words of 16 bits. Each request carries an 18-bit word address, 16 bits of write data, two byte enables and a read/write flag. A valid/ready handshake accepts one request at a time. The controller splits the address into a 9-bit row and a 9-bit column and sends them one after the other on a shared 9-bit address bus. It also sequences the row strobe, the two byte-lane column strobes, the write strobe and the output-enable strobe. Every delay is counted in clocks, and each count is a parameter.

A row stays open after an access. A later request that falls in the same row needs only a column cycle. A request for a different row first precharges the device and then opens the new row. A free-running interval counter schedules a refresh cycle in which both column strobes go active before the row strobe. This refresh takes priority over new requests and closes any open row. Read data comes back on a response bus, qualified by a one-clock valid pulse.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: The row is reqAddr[17:9] and is on dramAddr when dramRasN falls. The column is reqAddr[8:0] and is on dramAddr when a column strobe falls. A write to address A therefore lands in the cell with row A[17:9] and column A[8:0].
- R2: reqByteEn[0] selects the low lane (dq[7:0], strobe dramCasLN). reqByteEn[1] selects the high lane (dq[15:8], strobe dramCasUN). A write changes only the enabled lanes.
- R3: During a write, dramWeN is low and dramOeN is high, and dramDqOe is high while the column strobes are low. dramWeN only falls while both column strobes are high. dramDqOe is never high while dramWeN is high.
- R4: A read holds dramWeN high and dramOeN low. It returns the enabled lanes on rspData with a one-clock rspValid pulse, and any lane that is not enabled reads as zero. The bus is sampled T_RDSAMP clocks after the column strobe falls.
- R5: A request whose row matches the open row causes no new fall of dramRasN.
- R6: Before each row-opening fall, dramRasN is high for at least T_RP clocks. It is then low for at least T_RCD clocks before a column strobe falls.
- R7: A refresh starts at least once every REF_INTERVAL clocks, with a small extra delay allowed when an access is in progress. In a refresh, both column strobes are low before dramRasN falls, and dramDqOe stays low.
- R8: reqReady is low while a refresh is pending or running. After a refresh no row is open, so the next access opens its row again.
- R9: In reset, all strobes are high, dramDqOe and rspValid are low, and reqReady is high once reset is released.
- R10: A request is taken only when reqValid and reqReady are both high. reqReady then stays low until the column cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address, row in upper 9 bits |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Byte-lane enables, bit 0 = low lane |
| rspValid | output | 1 | One-clock pulse with read data |
| rspData | output | 16 | Read data, disabled lanes zero |
| dramAddr | output | 9 | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasLN | output | 1 | Low-lane column strobe, active low |
| dramCasUN | output | 1 | High-lane column strobe, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDqOut | output | 16 | Data driven toward the memory |
| dramDqOe | output | 1 | Drive enable for dramDqOut |
| dramDqIn | input | 16 | Data returned by the memory |

## Verification
A stale open-row register produces either an extra row opening or a missing one on the very next access. This shows up as a changed count of row-strobe falls, or as data landing in the wrong cell when the following read returns. A wrong state-machine count shrinks the precharge or row-to-column gap at the pins on the first affected access. A refresh counter that stalls stops the refreshes within one interval. Strobe mix-ups between lanes or between read and write corrupt the word that is read back immediately afterwards.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [3:0] {
    S_IDLE,   // row closed or held open, waiting
    S_PRE,    // row strobe high, precharge
    S_ACT,    // row strobe low, row address held
    S_CSET,   // column address and write strobe set up
    S_COL,    // column strobes low
    S_CHI,    // column strobes high before next column cycle
    S_RCAS,   // refresh: column strobes low, row strobe high
    S_RRAS,   // refresh: row strobe low
    S_RPRE    // refresh: precharge afterwards
  } fpmState_t;

  typedef struct packed {
    logic       ras;
    logic [1:0] cas;
    logic       we;
    logic       oe;
    logic       dqOe;
    logic       colSel;
    logic       capture;
    logic       load;
  } fpmStrobe_t;

endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int T_RP         = 10,
  parameter int T_RCD        = 9,
  parameter int T_CAS        = 4,
  parameter int T_CP         = 2,
  parameter int T_RDSAMP     = 3,
  parameter int T_CSR        = 2,
  parameter int T_RREF       = 12,
  parameter int REF_INTERVAL = 3000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic       rowHit,
  input  logic       curWrite,
  input  logic [1:0] curBe,
  output fpmStrobe_t strobe
);

  localparam int CNT_W = $clog2(T_RP + T_RCD + T_CAS + T_CP + T_CSR + T_RREF + 2);
  localparam int REF_W = $clog2(REF_INTERVAL + 1);

  fpmState_t        state, stateNext;
  logic [CNT_W-1:0] cnt;
  logic [REF_W-1:0] refCnt;
  logic             refTick, refPending, refAfterPre, rowOpen;
  logic             accept, enterRef;

  assign reqReady = (state == S_IDLE) && !refPending;
  assign accept   = reqValid && reqReady;
  assign refTick  = (refCnt == REF_W'(REF_INTERVAL - 1));
  assign enterRef = (stateNext == S_RCAS) && (state != S_RCAS);

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (refPending)          stateNext = rowOpen ? S_PRE : S_RCAS;
        else if (accept) begin
          if (rowOpen && rowHit) stateNext = S_CSET;
          else if (rowOpen)      stateNext = S_PRE;
          else                   stateNext = S_ACT;
        end
      end
      S_PRE:  if (cnt == CNT_W'(T_RP - 1))   stateNext = refAfterPre ? S_RCAS : S_ACT;
      S_ACT:  if (cnt == CNT_W'(T_RCD - 1))  stateNext = S_CSET;
      S_CSET:                                stateNext = S_COL;
      S_COL:  if (cnt == CNT_W'(T_CAS - 1))  stateNext = S_CHI;
      S_CHI:  if (cnt == CNT_W'(T_CP - 1))   stateNext = S_IDLE;
      S_RCAS: if (cnt == CNT_W'(T_CSR - 1))  stateNext = S_RRAS;
      S_RRAS: if (cnt == CNT_W'(T_RREF - 1)) stateNext = S_RPRE;
      S_RPRE: if (cnt == CNT_W'(T_RP - 1))   stateNext = S_IDLE;
      default:                               stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= S_IDLE;
      cnt         <= '0;
      refCnt      <= '0;
      refPending  <= 1'b0;
      refAfterPre <= 1'b0;
      rowOpen     <= 1'b0;
    end else begin
      state  <= stateNext;
      cnt    <= (stateNext != state) ? '0 : cnt + 1'b1;
      refCnt <= refTick ? '0 : refCnt + 1'b1;

      if (refTick)       refPending <= 1'b1;
      else if (enterRef) refPending <= 1'b0;

      if (state == S_IDLE && refPending && rowOpen) refAfterPre <= 1'b1;
      else if (state == S_PRE && stateNext != S_PRE) refAfterPre <= 1'b0;

      if (stateNext == S_ACT)                               rowOpen <= 1'b1;
      else if (stateNext == S_PRE || stateNext == S_RCAS)   rowOpen <= 1'b0;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.load    = accept;
    strobe.ras     = ((state == S_IDLE) && rowOpen) || (state == S_ACT) ||
                     (state == S_CSET) || (state == S_COL) || (state == S_CHI) ||
                     (state == S_RRAS);
    strobe.colSel  = (state == S_CSET) || (state == S_COL) || (state == S_CHI);
    strobe.we      = ((state == S_CSET) || (state == S_COL)) && curWrite;
    strobe.dqOe    = ((state == S_CSET) || (state == S_COL)) && curWrite;
    strobe.oe      = (state == S_COL) && !curWrite;
    strobe.capture = (state == S_COL) && !curWrite && (cnt == CNT_W'(T_RDSAMP));
    if (state == S_COL)                          strobe.cas = curBe;
    else if (state == S_RCAS || state == S_RRAS) strobe.cas = 2'b11;
  end

endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
#(
  parameter int ROW_W  = 9,
  parameter int COL_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  fpmStrobe_t             strobe,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqByteEn,
  output logic                   rowHit,
  output logic                   curWrite,
  output logic [DATA_W/8-1:0]    curBe,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspData,
  output logic [ROW_W-1:0]       dramAddr,
  output logic                   dramRasN,
  output logic [DATA_W/8-1:0]    dramCasN,
  output logic                   dramWeN,
  output logic                   dramOeN,
  output logic [DATA_W-1:0]      dramDqOut,
  output logic                   dramDqOe,
  input  logic [DATA_W-1:0]      dramDqIn
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int LANES  = DATA_W / 8;

  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic [DATA_W-1:0] curWdata;

  assign rowHit = (reqAddr[ADDR_W-1:COL_W] == curRow);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow   <= '0;
      curCol   <= '0;
      curWdata <= '0;
      curBe    <= '0;
      curWrite <= 1'b0;
    end else if (strobe.load) begin
      curRow   <= reqAddr[ADDR_W-1:COL_W];
      curCol   <= reqAddr[COL_W-1:0];
      curWdata <= reqWdata;
      curBe    <= reqByteEn;
      curWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dramRasN  <= 1'b1;
      dramCasN  <= '1;
      dramWeN   <= 1'b1;
      dramOeN   <= 1'b1;
      dramDqOe  <= 1'b0;
      dramAddr  <= '0;
      dramDqOut <= '0;
    end else begin
      dramRasN  <= !strobe.ras;
      dramCasN  <= ~strobe.cas;
      dramWeN   <= !strobe.we;
      dramOeN   <= !strobe.oe;
      dramDqOe  <= strobe.dqOe;
      dramAddr  <= strobe.colSel ? ROW_W'(curCol) : curRow;
      dramDqOut <= curWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strobe.capture;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rstN)               rspData[l*8 +: 8] <= '0;
      else if (strobe.capture) rspData[l*8 +: 8] <= curBe[l] ? dramDqIn[l*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W        = 9,
  parameter int COL_W        = 9,
  parameter int DATA_W       = 16,
  parameter int T_RP         = 10,
  parameter int T_RCD        = 9,
  parameter int T_CAS        = 4,
  parameter int T_CP         = 2,
  parameter int T_RDSAMP     = 3,
  parameter int T_CSR        = 2,
  parameter int T_RREF       = 12,
  parameter int REF_INTERVAL = 3000
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [1:0]             reqByteEn,
  output logic                   rspValid,
  output logic [DATA_W-1:0]      rspData,
  output logic [ROW_W-1:0]       dramAddr,
  output logic                   dramRasN,
  output logic                   dramCasLN,
  output logic                   dramCasUN,
  output logic                   dramWeN,
  output logic                   dramOeN,
  output logic [DATA_W-1:0]      dramDqOut,
  output logic                   dramDqOe,
  input  logic [DATA_W-1:0]      dramDqIn
);

  fpmStrobe_t strobe;
  logic       rowHit, curWrite;
  logic [1:0] curBe, casN;

  fpm_ctrl #(
    .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
    .T_RDSAMP(T_RDSAMP), .T_CSR(T_CSR), .T_RREF(T_RREF),
    .REF_INTERVAL(REF_INTERVAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .rowHit(rowHit), .curWrite(curWrite), .curBe(curBe), .strobe(strobe)
  );

  fpm_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .rowHit(rowHit), .curWrite(curWrite), .curBe(curBe),
    .rspValid(rspValid), .rspData(rspData),
    .dramAddr(dramAddr), .dramRasN(dramRasN), .dramCasN(casN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  assign dramCasLN = casN[0];
  assign dramCasUN = casN[1];

endmodule

// File: rtl/fpm_chk.sv
module fpm_chk #(
  parameter int T_RP  = 10,
  parameter int T_RCD = 9
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic rspValid,
  input logic dramRasN,
  input logic dramCasLN,
  input logic dramCasUN,
  input logic dramWeN,
  input logic dramOeN,
  input logic dramDqOe
);

  localparam int CW = $clog2(T_RP + T_RCD + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] rasHighCnt, rasLowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasHighCnt <= CW'(T_RP);
      rasLowCnt  <= '0;
    end else if (dramRasN) begin
      rasHighCnt <= (rasHighCnt == CMAX) ? CMAX : rasHighCnt + 1'b1;
      rasLowCnt  <= '0;
    end else begin
      rasHighCnt <= '0;
      rasLowCnt  <= (rasLowCnt == CMAX) ? CMAX : rasLowCnt + 1'b1;
    end
  end

  // R3
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> dramOeN);

  // R3
  dq_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> !dramWeN);

  // R3
  early_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramWeN) |-> (dramCasLN && dramCasUN));

  // R7
  cbr_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramRasN) && !(dramCasLN && dramCasUN)) |-> (!dramCasLN && !dramCasUN && !dramDqOe));

  // R8
  ref_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dramRasN && !dramCasLN && !dramCasUN) |-> !reqReady);

  // R4
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R6
  precharge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (rasHighCnt >= CW'(T_RP)));

  // R6
  rcd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dramRasN && ($fell(dramCasLN) || $fell(dramCasUN))) |-> (rasLowCnt >= CW'(T_RCD)));

endmodule

bind fpm_dram_ctrl fpm_chk #(.T_RP(T_RP), .T_RCD(T_RCD)) uChk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .dramRasN(dramRasN), .dramCasLN(dramCasLN), .dramCasUN(dramCasUN),
  .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOe(dramDqOe)
);

// File: tb/tb_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module tb_fpm_dram_ctrl;

  localparam int T_RP   = 10;
  localparam int T_RCD  = 9;
  localparam int REF    = 400;
  localparam int SLACK  = 60;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic        reqReady, rspValid;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic [15:0] rspData, dramDqOut, dramDqIn;
  logic [8:0]  dramAddr;
  logic        dramRasN, dramCasLN, dramCasUN, dramWeN, dramOeN, dramDqOe;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl #(.T_RP(T_RP), .T_RCD(T_RCD), .REF_INTERVAL(REF)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .rspValid(rspValid), .rspData(rspData), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasLN(dramCasLN), .dramCasUN(dramCasUN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOut(dramDqOut),
    .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  // ---------------- memory model (sampled at negedge) ----------------
  logic [15:0] mem [int unsigned];
  logic [8:0]  rowM = '0;
  logic [15:0] rdWord = '0;
  logic        pRas = 1'b1, pCasL = 1'b1, pCasU = 1'b1;
  int opens = 0, refreshes = 0, protoErr = 0, readyViol = 0;
  int hiCnt = 1000, loCnt = 0, minPre = 1000, minRcd = 1000;
  int cyc = 0, lastRef = -1, minGap = 1000000, maxGap = 0;

  function automatic logic [15:0] peek(input int unsigned k);
    return mem.exists(k) ? mem[k] : 16'h0000;
  endfunction

  assign dramDqIn[7:0]  = (!dramRasN && !dramCasLN && !dramOeN && dramWeN) ? rdWord[7:0]  : 8'hEE;
  assign dramDqIn[15:8] = (!dramRasN && !dramCasUN && !dramOeN && dramWeN) ? rdWord[15:8] : 8'hEE;

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (pRas && !dramRasN) begin
        if (!dramCasLN && !dramCasUN) begin
          refreshes++;
          if (dramDqOe) protoErr++;
          if (lastRef >= 0) begin
            if (cyc - lastRef < minGap) minGap = cyc - lastRef;
            if (cyc - lastRef > maxGap) maxGap = cyc - lastRef;
          end
          lastRef = cyc;
        end else if (!dramCasLN || !dramCasUN) begin
          protoErr++;
        end else begin
          opens++;
          rowM = dramAddr;
          if (hiCnt < minPre) minPre = hiCnt;
        end
      end
      if (!dramRasN && ((pCasL && !dramCasLN) || (pCasU && !dramCasUN)) && !pRas) begin
        int unsigned k;
        logic [15:0] w;
        k = {14'd0, rowM, dramAddr};
        w = peek(k);
        if (loCnt < minRcd) minRcd = loCnt;
        if (!dramWeN) begin
          if (!dramDqOe) protoErr++;
          if (pCasL && !dramCasLN) w[7:0]  = dramDqOut[7:0];
          if (pCasU && !dramCasUN) w[15:8] = dramDqOut[15:8];
          mem[k] = w;
        end
        rdWord = w;
      end
      if (dramDqOe && dramWeN) protoErr++;
      if (!dramCasLN && !dramCasUN && (dramRasN || !pRas) && reqReady && dramWeN && dramOeN)
        readyViol++;
      if (dramRasN) begin hiCnt++; loCnt = 0; end
      else          begin loCnt++; hiCnt = 0; end
    end
    pRas  = dramRasN;
    pCasL = dramCasLN;
    pCasU = dramCasUN;
  end

  // ---------------- bookkeeping ----------------
  int nTests = 0, nFail = 0;
  bit done = 1'b0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkIn(input string req, input string what,
                         input int act, input int lo, input int hi);
    nTests++;
    if (act < lo || act > hi) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  function automatic logic [17:0] mk(input int row, input int col);
    return {row[8:0], col[8:0]};
  endfunction

  task automatic waitReady();
    for (int i = 0; i < 500 && !reqReady; i++) @(negedge clk);
  endtask

  task automatic issue(input logic wr, input logic [17:0] a,
                       input logic [15:0] d, input logic [1:0] be);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqByteEn = be;
    waitReady();
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic doWrite(input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    issue(1'b1, a, d, be);
    waitReady();
  endtask

  task automatic doRead(input logic [17:0] a, input logic [1:0] be, output logic [15:0] q);
    q = 16'hBAD0;
    issue(1'b0, a, 16'h0, be);
    for (int i = 0; i < 200; i++) begin
      if (rspValid) begin q = rspData; break; end
      @(negedge clk);
    end
    waitReady();
  endtask

  task automatic syncAfterRefresh();
    int r;
    r = refreshes;
    for (int i = 0; i < 2 * REF && refreshes == r; i++) @(negedge clk);
    waitReady();
  endtask

  // ---------------- scenarios ----------------
  task automatic tReset();
    @(negedge clk);
    check("R9", "strobes in reset", {dramRasN, dramCasLN, dramCasUN, dramWeN, dramOeN, dramDqOe, rspValid},
          7'b1111100);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", "ready after reset", reqReady, 1'b1);
  endtask

  task automatic tWord();
    logic [15:0] q;
    doWrite(mk(300, 17), 16'hA5C3, 2'b11);
    check("R1", "cell at row/col", peek({14'd0, 9'd300, 9'd17}), 16'hA5C3);
    check("R1", "transposed cell untouched", peek({14'd0, 9'd17, 9'd300}), 16'h0000);
    doRead(mk(300, 17), 2'b11, q);
    check("R4", "word read", q, 16'hA5C3);
  endtask

  task automatic tBytes();
    logic [15:0] q;
    doWrite(mk(5, 40), 16'hFFFF, 2'b11);
    doWrite(mk(5, 40), 16'h0012, 2'b01);
    check("R2", "low lane write", peek({14'd0, 9'd5, 9'd40}), 16'hFF12);
    doWrite(mk(5, 40), 16'h3400, 2'b10);
    check("R2", "high lane write", peek({14'd0, 9'd5, 9'd40}), 16'h3412);
    doRead(mk(5, 40), 2'b01, q);
    check("R4", "low lane read, high zero", q, 16'h0012);
    doRead(mk(5, 40), 2'b10, q);
    check("R4", "high lane read, low zero", q, 16'h3400);
  endtask

  task automatic tPageHit();
    int o;
    logic [15:0] q;
    syncAfterRefresh();
    doWrite(mk(7, 3), 16'h1111, 2'b11);
    o = opens;
    doWrite(mk(7, 4), 16'h2222, 2'b11);
    doRead(mk(7, 3), 2'b11, q);
    check("R5", "no row open on hit", opens - o, 0);
    check("R5", "hit read data", q, 16'h1111);
  endtask

  task automatic tRowMiss();
    int o;
    logic [15:0] q;
    syncAfterRefresh();
    doWrite(mk(8, 9), 16'h0F0F, 2'b11);
    o = opens;
    doWrite(mk(9, 9), 16'hF0F0, 2'b11);
    doRead(mk(8, 9), 2'b11, q);
    check("R6", "two opens for two misses", opens - o, 2);
    check("R6", "miss read data", q, 16'h0F0F);
  endtask

  task automatic tRefreshCloses();
    int o;
    doWrite(mk(12, 1), 16'h7777, 2'b11);
    syncAfterRefresh();
    o = opens;
    doWrite(mk(12, 2), 16'h8888, 2'b11);
    check("R8", "row reopened after refresh", opens - o, 1);
  endtask

  task automatic tHandshake();
    syncAfterRefresh();
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = mk(20, 20); reqWdata = 16'h5A5A; reqByteEn = 2'b11;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10", "ready low after accept", reqReady, 1'b0);
    reqAddr = mk(21, 21);
    waitReady();
    check("R10", "held request not retaken", peek({14'd0, 9'd21, 9'd21}), 16'h0000);
    check("R10", "accepted request written", peek({14'd0, 9'd20, 9'd20}), 16'h5A5A);
  endtask

  task automatic tRefreshIdle();
    int r;
    r = refreshes;
    repeat (10 * REF) @(negedge clk);
    checkIn("R7", "refreshes in 10 intervals", refreshes - r, 9, 11);
    checkIn("R7", "max refresh gap", maxGap, REF - SLACK, REF + SLACK);
    checkIn("R7", "min refresh gap", minGap, REF - SLACK, REF + SLACK);
  endtask

  task automatic tFinal();
    checkIn("R6", "min precharge clocks", minPre, T_RP, 1000);
    checkIn("R6", "min row-to-column clocks", minRcd, T_RCD, 1000);
    check("R3", "strobe protocol errors", protoErr, 0);
    check("R8", "ready during refresh", readyViol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    tReset();
    tWord();
    tBytes();
    tPageHit();
    tRowMiss();
    tRefreshCloses();
    tHandshake();
    tRefreshIdle();
    tFinal();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule